// File: doc/BRIEF.md
# Full-Map Write-Update Directory Controller

This block is the home-node directory for a line-granular write-update coherence scheme. Every memory line has a directory entry. The entry holds one presence bit per cache, an exclusive-owner flag and a pending flag for a forwarding transaction that has not finished. Caches send three kinds of request message: a write to a line they hold, a read miss and a write miss. The block takes at most one request per cycle. It emits its outgoing messages one cycle after it accepts a request, always in acceptance order, so an order-keeping network delivers them in request order.

On a write, the block stores the word in the local line store. It multicasts an update that carries the word to every other cache with a presence bit set. It sends the writer an acknowledgement that states how many update acknowledgements to collect. Those acknowledgements travel from cache to cache and never pass through this block.

On a miss, the line store supplies the data unless another cache owns the line exclusively. In that case the block sends a forward message to the owner, naming the requester. The owner sends the line to the requester and writes it back to the home node. The line is blocked to new requests until that writeback arrives. A requester that finds no other sharer receives an exclusive grant.

Top module: `dir_update_ctrl`

## Requirements
- R1: After reset all directory entries are empty, every stored word is zero, `req_ready` is high and no message output is valid.
- R2: A write (request kind 0) from cache `s` produces, one cycle later, an update with `upd_mask` equal to the line's presence bits with bit `s` cleared, carrying the written word and line. `upd_valid` is raised only when that mask is nonzero.
- R3: A write is answered with a response of kind 0 (write acknowledgement) to the writer, and `rsp_count` equals the number of bits in the update mask.
- R4: A write stores its word in the line store, and a later miss that memory serves returns that word.
- R5: A miss (kind 1 read miss or kind 2 write miss) on a line with no exclusive owner other than the requester is answered with the stored word. The response kind is 2 (exclusive) when no other cache has a presence bit set and 1 (shared) otherwise.
- R6: A miss on a line that another cache owns exclusively produces a forward message to that owner, naming the requester and the line, and no response. Until a writeback for that line arrives, `req_ready` is low for requests to it. The writeback word replaces the stored word.
- R7: Every accepted miss sets the requester's presence bit. A line stops being exclusive as soon as a second cache joins it, which later writes show in their counts.
- R8: While one line waits for a writeback, requests to other lines are accepted and answered normally.
- R9: Each accepted request yields its messages exactly one cycle after acceptance, so messages leave in acceptance order.
- R10: Request kind 3 is accepted but produces no message and leaves the directory entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request message present |
| req_ready | output | 1 | Request line is not waiting for a writeback |
| req_kind | input | 2 | 0 write, 1 read miss, 2 write miss, 3 no operation |
| req_src | input | $clog2(NC) | Requesting cache |
| req_line | input | $clog2(LINES) | Line index |
| req_data | input | DW | Word carried by a write |
| wb_valid | input | 1 | Writeback from a forwarding owner |
| wb_line | input | $clog2(LINES) | Writeback line |
| wb_data | input | DW | Writeback word |
| upd_valid | output | 1 | Update multicast valid |
| upd_mask | output | NC | Caches that receive the update |
| upd_line | output | $clog2(LINES) | Updated line |
| upd_data | output | DW | New word |
| rsp_valid | output | 1 | Response to requester valid |
| rsp_kind | output | 2 | 0 write ack, 1 shared data, 2 exclusive data |
| rsp_dst | output | $clog2(NC) | Destination cache |
| rsp_count | output | $clog2(NC+1) | Update acknowledgements to expect |
| rsp_line | output | $clog2(LINES) | Response line |
| rsp_data | output | DW | Line word for data responses |
| fwd_valid | output | 1 | Forward message valid |
| fwd_owner | output | $clog2(NC) | Exclusive owner that must supply the line |
| fwd_dst | output | $clog2(NC) | Requester that receives the line |
| fwd_line | output | $clog2(LINES) | Forwarded line |

## Verification
A directed run walks one line through each state of its life. It starts empty, which exercises the exclusive grant from a zeroed store. A write by the sole holder then checks a zero count with no multicast. A second cache's miss triggers a forward and blocks the line, while a request to another line shows that the block leaves other lines alone. The writeback arrives, and later misses and writes check the shared grant and the multicast mask that excludes the writer. Random traffic follows on four lines with any cache and any kind, plus writebacks to blocked lines at random delays. Concentrating on four lines forces frequent collisions between forwards, writes and misses, which separates a mask error, a miscount of acknowledgements and stale line data from a request that was wrongly held or wrongly let through.

// File: rtl/dir_upd_pkg.sv
package dir_upd_pkg;
   typedef enum logic [1:0] {
      K_WRITE  = 2'd0,
      K_RDMISS = 2'd1,
      K_WRMISS = 2'd2,
      K_NOP    = 2'd3
   } req_kind_e;

   typedef enum logic [1:0] {
      RSP_WACK   = 2'd0,
      RSP_SHARED = 2'd1,
      RSP_EXCL   = 2'd2
   } rsp_kind_e;
endpackage

// File: rtl/dir_entry_table.sv
module dir_entry_table #(
   parameter int NC    = 8,
   parameter int LINES = 16,
   localparam int LW   = $clog2(LINES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [LW-1:0] rd_line,
   output logic [NC-1:0] rd_sharers,
   output logic          rd_excl,
   output logic          rd_busy,
   input  logic          wr_en,
   input  logic [LW-1:0] wr_line,
   input  logic [NC-1:0] wr_sharers,
   input  logic          wr_excl,
   input  logic          wr_set_busy,
   input  logic          clr_en,
   input  logic [LW-1:0] clr_line
);
   logic [NC-1:0] sh_all [LINES];
   logic [LINES-1:0] ex_all;
   logic [LINES-1:0] bz_all;

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [NC-1:0] sh_q;
      logic          ex_q;
      logic          bz_q;
      logic          hit_wr;
      logic          hit_clr;

      assign hit_wr  = wr_en  && (wr_line  == LW'(g));
      assign hit_clr = clr_en && (clr_line == LW'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sh_q <= '0;
            ex_q <= 1'b0;
            bz_q <= 1'b0;
         end else begin
            if (hit_wr) begin
               sh_q <= wr_sharers;
               ex_q <= wr_excl;
            end
            if (hit_wr && wr_set_busy)
               bz_q <= 1'b1;
            else if (hit_clr)
               bz_q <= 1'b0;
         end
      end

      assign sh_all[g] = sh_q;
      assign ex_all[g] = ex_q;
      assign bz_all[g] = bz_q;
   end

   assign rd_sharers = sh_all[rd_line];
   assign rd_excl    = ex_all[rd_line];
   assign rd_busy    = bz_all[rd_line];
endmodule

// File: rtl/dir_line_store.sv
module dir_line_store #(
   parameter int LINES = 16,
   parameter int DW    = 32,
   localparam int LW   = $clog2(LINES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [LW-1:0] rd_line,
   output logic [DW-1:0] rd_data,
   input  logic          a_we,
   input  logic [LW-1:0] a_line,
   input  logic [DW-1:0] a_data,
   input  logic          b_we,
   input  logic [LW-1:0] b_line,
   input  logic [DW-1:0] b_data
);
   logic [DW-1:0] mem_q [LINES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < LINES; i++) mem_q[i] <= '0;
      end else begin
         if (a_we) mem_q[a_line] <= a_data;
         // writebacks only target lines that block requests, so the ports never collide
         if (b_we) mem_q[b_line] <= b_data;
      end
   end

   assign rd_data = mem_q[rd_line];
endmodule

// File: rtl/dir_decide.sv
module dir_decide
   import dir_upd_pkg::*;
#(
   parameter int NC  = 8,
   localparam int SW = $clog2(NC),
   localparam int CW = $clog2(NC + 1)
) (
   input  logic          accept,
   input  logic [1:0]    kind,
   input  logic [SW-1:0] src,
   input  logic [NC-1:0] sharers,
   input  logic          excl,
   output logic          upd_en,
   output logic [NC-1:0] upd_mask,
   output logic          rsp_en,
   output logic [1:0]    rsp_kind,
   output logic [CW-1:0] rsp_count,
   output logic          fwd_en,
   output logic [SW-1:0] owner,
   output logic          tbl_we,
   output logic [NC-1:0] new_sharers,
   output logic          new_excl,
   output logic          set_busy,
   output logic          mem_we
);
   logic [NC-1:0] src_oh;
   logic [NC-1:0] others;
   logic [CW-1:0] others_cnt;

   assign src_oh = {{(NC-1){1'b0}}, 1'b1} << src;
   assign others = sharers & ~src_oh;

   always_comb begin
      others_cnt = '0;
      for (int i = 0; i < NC; i++) others_cnt = others_cnt + CW'(others[i]);
   end

   // lowest set presence bit; an exclusive line has exactly one
   always_comb begin
      owner = '0;
      for (int i = NC - 1; i >= 0; i--)
         if (sharers[i]) owner = SW'(i);
   end

   always_comb begin
      upd_en      = 1'b0;
      upd_mask    = others;
      rsp_en      = 1'b0;
      rsp_kind    = RSP_WACK;
      rsp_count   = others_cnt;
      fwd_en      = 1'b0;
      tbl_we      = 1'b0;
      new_sharers = sharers | src_oh;
      new_excl    = (others == '0);
      set_busy    = 1'b0;
      mem_we      = 1'b0;
      if (accept) begin
         unique case (req_kind_e'(kind))
            K_WRITE: begin
               upd_en = (others != '0);
               rsp_en = 1'b1;
               tbl_we = 1'b1;
               mem_we = 1'b1;
            end
            K_RDMISS, K_WRMISS: begin
               tbl_we = 1'b1;
               if (excl && (others != '0)) begin
                  fwd_en   = 1'b1;
                  new_excl = 1'b0;
                  set_busy = 1'b1;
               end else begin
                  rsp_en   = 1'b1;
                  rsp_kind = (others == '0) ? RSP_EXCL : RSP_SHARED;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/dir_update_ctrl.sv
module dir_update_ctrl #(
   parameter int NC    = 8,
   parameter int LINES = 16,
   parameter int DW    = 32,
   localparam int SW   = $clog2(NC),
   localparam int LW   = $clog2(LINES),
   localparam int CW   = $clog2(NC + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [1:0]    req_kind,
   input  logic [SW-1:0] req_src,
   input  logic [LW-1:0] req_line,
   input  logic [DW-1:0] req_data,
   input  logic          wb_valid,
   input  logic [LW-1:0] wb_line,
   input  logic [DW-1:0] wb_data,
   output logic          upd_valid,
   output logic [NC-1:0] upd_mask,
   output logic [LW-1:0] upd_line,
   output logic [DW-1:0] upd_data,
   output logic          rsp_valid,
   output logic [1:0]    rsp_kind,
   output logic [SW-1:0] rsp_dst,
   output logic [CW-1:0] rsp_count,
   output logic [LW-1:0] rsp_line,
   output logic [DW-1:0] rsp_data,
   output logic          fwd_valid,
   output logic [SW-1:0] fwd_owner,
   output logic [SW-1:0] fwd_dst,
   output logic [LW-1:0] fwd_line
);
   if (NC < 2) begin : g_bad_nc
      $error("dir_update_ctrl: NC must be at least 2");
   end
   if (LINES < 2) begin : g_bad_lines
      $error("dir_update_ctrl: LINES must be at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("dir_update_ctrl: DW must be positive");
   end

   logic [NC-1:0] cur_sharers;
   logic          cur_excl;
   logic          cur_busy;
   logic [DW-1:0] cur_data;
   logic          accept;

   logic          d_upd_en, d_rsp_en, d_fwd_en;
   logic [NC-1:0] d_upd_mask;
   logic [1:0]    d_rsp_kind;
   logic [CW-1:0] d_rsp_count;
   logic [SW-1:0] d_owner;
   logic          d_tbl_we, d_new_excl, d_set_busy, d_mem_we;
   logic [NC-1:0] d_new_sharers;

   assign req_ready = !cur_busy;
   assign accept    = req_valid && req_ready;

   dir_entry_table #(.NC(NC), .LINES(LINES)) i_table (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_line     (req_line),
      .rd_sharers  (cur_sharers),
      .rd_excl     (cur_excl),
      .rd_busy     (cur_busy),
      .wr_en       (d_tbl_we),
      .wr_line     (req_line),
      .wr_sharers  (d_new_sharers),
      .wr_excl     (d_new_excl),
      .wr_set_busy (d_set_busy),
      .clr_en      (wb_valid),
      .clr_line    (wb_line)
   );

   dir_line_store #(.LINES(LINES), .DW(DW)) i_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_line (req_line),
      .rd_data (cur_data),
      .a_we    (d_mem_we),
      .a_line  (req_line),
      .a_data  (req_data),
      .b_we    (wb_valid),
      .b_line  (wb_line),
      .b_data  (wb_data)
   );

   dir_decide #(.NC(NC)) i_decide (
      .accept      (accept),
      .kind        (req_kind),
      .src         (req_src),
      .sharers     (cur_sharers),
      .excl        (cur_excl),
      .upd_en      (d_upd_en),
      .upd_mask    (d_upd_mask),
      .rsp_en      (d_rsp_en),
      .rsp_kind    (d_rsp_kind),
      .rsp_count   (d_rsp_count),
      .fwd_en      (d_fwd_en),
      .owner       (d_owner),
      .tbl_we      (d_tbl_we),
      .new_sharers (d_new_sharers),
      .new_excl    (d_new_excl),
      .set_busy    (d_set_busy),
      .mem_we      (d_mem_we)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         upd_valid <= 1'b0;
         upd_mask  <= '0;
         upd_line  <= '0;
         upd_data  <= '0;
         rsp_valid <= 1'b0;
         rsp_kind  <= '0;
         rsp_dst   <= '0;
         rsp_count <= '0;
         rsp_line  <= '0;
         rsp_data  <= '0;
         fwd_valid <= 1'b0;
         fwd_owner <= '0;
         fwd_dst   <= '0;
         fwd_line  <= '0;
      end else begin
         upd_valid <= d_upd_en;
         upd_mask  <= d_upd_mask;
         upd_line  <= req_line;
         upd_data  <= req_data;
         rsp_valid <= d_rsp_en;
         rsp_kind  <= d_rsp_kind;
         rsp_dst   <= req_src;
         rsp_count <= d_rsp_count;
         rsp_line  <= req_line;
         rsp_data  <= cur_data;
         fwd_valid <= d_fwd_en;
         fwd_owner <= d_owner;
         fwd_dst   <= req_src;
         fwd_line  <= req_line;
      end
   end
endmodule

// File: rtl/dir_update_ctrl_chk.sv
module dir_update_ctrl_chk #(
   parameter int NC    = 8,
   parameter int LINES = 16,
   parameter int DW    = 32,
   localparam int SW   = $clog2(NC),
   localparam int LW   = $clog2(LINES),
   localparam int CW   = $clog2(NC + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic [1:0]    req_kind,
   input logic [SW-1:0] req_src,
   input logic [LW-1:0] req_line,
   input logic [DW-1:0] req_data,
   input logic          wb_valid,
   input logic [LW-1:0] wb_line,
   input logic [DW-1:0] wb_data,
   input logic          upd_valid,
   input logic [NC-1:0] upd_mask,
   input logic [LW-1:0] upd_line,
   input logic [DW-1:0] upd_data,
   input logic          rsp_valid,
   input logic [1:0]    rsp_kind,
   input logic [SW-1:0] rsp_dst,
   input logic [CW-1:0] rsp_count,
   input logic [LW-1:0] rsp_line,
   input logic [DW-1:0] rsp_data,
   input logic          fwd_valid,
   input logic [SW-1:0] fwd_owner,
   input logic [SW-1:0] fwd_dst,
   input logic [LW-1:0] fwd_line
);
   // lines seen forwarded at the outputs and not yet written back
   logic [LINES-1:0] held_q;

   always_ff @(posedge clk) begin
      if (!rst_n) held_q <= '0;
      else begin
         if (fwd_valid) held_q[fwd_line] <= 1'b1;
         if (wb_valid)  held_q[wb_line]  <= 1'b0;
      end
   end

   a_r1_quiet_after_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> !upd_valid && !rsp_valid && !fwd_valid);

   a_r2_update_skips_writer: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && rsp_valid && rsp_kind == 2'd0) |-> !upd_mask[rsp_dst]);

   a_r3_count_matches_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_kind == 2'd0) |->
         (rsp_count == CW'($countones(upd_mask))) && (upd_valid == (rsp_count != '0)));

   a_r5_data_reply_alone: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_kind != 2'd0) |-> !upd_valid && !fwd_valid);

   a_r6_forward_no_reply: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> !rsp_valid && !upd_valid && (fwd_owner != fwd_dst));

   a_r6_held_line_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      held_q[req_line] |-> !req_ready);

   a_r10_nop_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_kind == 2'd3) |=> !upd_valid && !rsp_valid && !fwd_valid);
endmodule

bind dir_update_ctrl dir_update_ctrl_chk #(.NC(NC), .LINES(LINES), .DW(DW)) i_chk (.*);

// File: tb/test_dir_update_ctrl.sv
module test_dir_update_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NC    = 8;
   localparam int LINES = 16;
   localparam int DW    = 32;
   localparam int SW    = $clog2(NC);
   localparam int LW    = $clog2(LINES);
   localparam int CW    = $clog2(NC + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [1:0]    req_kind = '0;
   logic [SW-1:0] req_src = '0;
   logic [LW-1:0] req_line = '0;
   logic [DW-1:0] req_data = '0;
   logic          wb_valid = 1'b0;
   logic [LW-1:0] wb_line = '0;
   logic [DW-1:0] wb_data = '0;
   logic          upd_valid;
   logic [NC-1:0] upd_mask;
   logic [LW-1:0] upd_line;
   logic [DW-1:0] upd_data;
   logic          rsp_valid;
   logic [1:0]    rsp_kind;
   logic [SW-1:0] rsp_dst;
   logic [CW-1:0] rsp_count;
   logic [LW-1:0] rsp_line;
   logic [DW-1:0] rsp_data;
   logic          fwd_valid;
   logic [SW-1:0] fwd_owner;
   logic [SW-1:0] fwd_dst;
   logic [LW-1:0] fwd_line;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dir_update_ctrl #(.NC(NC), .LINES(LINES), .DW(DW)) i_dir_update_ctrl (.*);

   int total = 0;
   int bad = 0;

   // reference directory
   logic [NC-1:0] m_sh [LINES];
   logic          m_ex [LINES];
   logic          m_busy [LINES];
   logic [DW-1:0] m_mem [LINES];

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int lowest_bit(input logic [NC-1:0] v);
      for (int i = 0; i < NC; i++) if (v[i]) return i;
      return 0;
   endfunction

   // called at a falling edge; drives one cycle and checks the outputs at the next falling edge
   task automatic step(input bit v, input int k, input int s, input int ln, input logic [DW-1:0] d,
                       input bit wbv, input int wbl, input logic [DW-1:0] wbd);
      logic [NC-1:0] soh, others;
      bit e_rdy, acc, e_uv, e_rv, e_fv;
      int e_rk, e_cnt, e_fo;
      logic [DW-1:0] e_rd;
      req_valid = v; req_kind = 2'(k); req_src = SW'(s); req_line = LW'(ln); req_data = d;
      wb_valid = wbv; wb_line = LW'(wbl); wb_data = wbd;
      #1;
      soh = '0; soh[s] = 1'b1;
      others = m_sh[ln] & ~soh;
      e_rdy = !m_busy[ln];
      if (v) chk("R6 R8 req_ready", 64'(req_ready), 64'(e_rdy));
      acc = v && e_rdy;
      e_uv = 0; e_rv = 0; e_fv = 0; e_rk = 0; e_cnt = 0; e_fo = 0; e_rd = m_mem[ln];
      if (acc) begin
         case (k)
            0: begin
               e_uv = (others != '0); e_rv = 1; e_rk = 0; e_cnt = $countones(others);
               m_mem[ln] = d; m_sh[ln] = m_sh[ln] | soh; m_ex[ln] = (others == '0);
            end
            1, 2: begin
               if (m_ex[ln] && others != '0) begin
                  e_fv = 1; e_fo = lowest_bit(others);
                  m_sh[ln] = m_sh[ln] | soh; m_ex[ln] = 0; m_busy[ln] = 1;
               end else begin
                  e_rv = 1; e_rk = (others == '0) ? 2 : 1;
                  m_sh[ln] = m_sh[ln] | soh; m_ex[ln] = (others == '0);
               end
            end
            default: ;
         endcase
      end
      if (wbv) begin
         m_mem[wbl] = wbd;
         m_busy[wbl] = 0;
      end
      @(negedge clk);
      chk("R2 upd_valid", 64'(upd_valid), 64'(e_uv));
      if (e_uv) begin
         chk("R2 upd_mask", 64'(upd_mask), 64'(others));
         chk("R2 upd_data", 64'(upd_data), 64'(d));
         chk("R2 upd_line", 64'(upd_line), 64'(ln));
      end
      chk("R9 rsp_valid", 64'(rsp_valid), 64'(e_rv));
      if (e_rv) begin
         chk("R5 rsp_kind", 64'(rsp_kind), 64'(e_rk));
         chk("R3 rsp_dst", 64'(rsp_dst), 64'(s));
         chk("R9 rsp_line", 64'(rsp_line), 64'(ln));
         if (e_rk == 0) chk("R3 rsp_count", 64'(rsp_count), 64'(e_cnt));
         else chk("R4 R5 rsp_data", 64'(rsp_data), 64'(e_rd));
      end
      chk("R6 fwd_valid", 64'(fwd_valid), 64'(e_fv));
      if (e_fv) begin
         chk("R6 fwd_owner", 64'(fwd_owner), 64'(e_fo));
         chk("R6 fwd_dst", 64'(fwd_dst), 64'(s));
         chk("R6 fwd_line", 64'(fwd_line), 64'(ln));
      end
      if (acc && k == 3) chk("R10 nop silent", 64'(upd_valid | rsp_valid | fwd_valid), 64'(0));
      req_valid = 0; wb_valid = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      for (int i = 0; i < LINES; i++) begin
         m_sh[i] = '0; m_ex[i] = 0; m_busy[i] = 0; m_mem[i] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: quiet outputs and ready after reset
      chk("R1 upd_valid", 64'(upd_valid), 64'(0));
      chk("R1 rsp_valid", 64'(rsp_valid), 64'(0));
      chk("R1 fwd_valid", 64'(fwd_valid), 64'(0));
      chk("R1 req_ready", 64'(req_ready), 64'(1));

      // R1 R5: first miss on an empty line gets exclusive zero data
      step(1, 1, 0, 3, '0, 0, 0, '0);
      chk("R1 zero data", 64'(rsp_data), 64'(0));
      chk("R5 excl grant", 64'(rsp_kind), 64'(2));
      // R3: sole holder writes, no updates expected
      step(1, 0, 0, 3, 32'h0000_00a5, 0, 0, '0);
      chk("R3 zero count", 64'(rsp_count), 64'(0));
      // R6: another cache misses on the exclusively owned line
      step(1, 1, 1, 3, '0, 0, 0, '0);
      chk("R6 forward to owner", 64'(fwd_owner), 64'(0));
      // R6: line is held
      step(1, 2, 2, 3, '0, 0, 0, '0);
      // R8: other line proceeds meanwhile
      step(1, 2, 2, 5, '0, 0, 0, '0);
      chk("R8 other line served", 64'(rsp_valid), 64'(1));
      // R6: writeback releases the line and refreshes memory
      step(0, 0, 0, 3, '0, 1, 3, 32'h0000_0077);
      step(1, 1, 2, 3, '0, 0, 0, '0);
      chk("R6 writeback data", 64'(rsp_data), 64'(32'h77));
      chk("R7 shared grant", 64'(rsp_kind), 64'(1));
      // R2 R7: write by cache 1 updates caches 0 and 2
      step(1, 0, 1, 3, 32'h0000_0011, 0, 0, '0);
      chk("R2 mask excludes writer", 64'(upd_mask), 64'(8'h05));
      chk("R7 count after sharing", 64'(rsp_count), 64'(2));
      // R4: written word served by memory
      step(1, 1, 4, 3, '0, 0, 0, '0);
      chk("R4 stored word", 64'(rsp_data), 64'(32'h11));
      // R10: no-op from cache 5 leaves the entry alone
      step(1, 3, 5, 3, '0, 0, 0, '0);
      step(1, 0, 0, 3, 32'h0000_0022, 0, 0, '0);
      chk("R10 entry unchanged", 64'(rsp_count), 64'(3));

      // random traffic on four lines
      for (int n = 0; n < 4000; n++) begin
         int r, k, busy_ln;
         bit wbv;
         r = $urandom % 10;
         k = (r < 4) ? 0 : (r < 7) ? 1 : (r < 9) ? 2 : 3;
         busy_ln = -1;
         for (int i = 0; i < LINES; i++) if (m_busy[i] && busy_ln < 0) busy_ln = i;
         wbv = (busy_ln >= 0) && ($urandom % 3 == 0);
         step(($urandom % 5) != 0, k, $urandom % NC, $urandom % 4, $urandom,
              wbv, wbv ? busy_ln : 0, $urandom);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule